// File: doc/BRIEF.md
# Video Processor CPU Register Interface

This block is the processor-facing register file of a tile-based video engine. A host CPU reaches it through a single-cycle strobe with a 3-bit register index and byte-wide write data. Read data comes back combinationally in the same cycle. The block keeps the scroll and VRAM pointer state that the rendering pipeline uses. It also holds the 256-byte sprite attribute store and the three status flags, and it raises the vertical-blank interrupt.

Register indices decode as follows: 0 control, 1 mask, 2 status, 3 sprite pointer, 4 sprite data, 5 scroll, 6 VRAM pointer, 7 VRAM data. Pointer registers hold 15 bits. Counted from the LSB they carry coarse X (5 bits), coarse Y (5), nametable select (2) and fine Y (3). An external timing counter supplies the scanline and dot. Sprite-zero hit and sprite overflow arrive as one-cycle strobes from the renderer. VRAM accesses are single-cycle requests, and the memory is assumed to return `vram_rdata` in the same cycle as `vram_rd`.

Top module: `vid_regif`

## Requirements
- R1: After a synchronous active-low reset, all of the following are zero: control, mask, both pointers, fine X, the write toggle, the flags, the read buffer, the bus latch, the sprite pointer and all sprite bytes. The irq output is low.
- R2: A write to index 0 stores the byte on `ctrl_bits` and copies data bits 1:0 into temporary pointer bits 11:10.
- R3: Writes to index 5 depend on the write toggle. With the toggle at 0, data bits 7:3 go to temporary bits 4:0 and data bits 2:0 go to fine X. With the toggle at 1, data bits 7:3 go to temporary bits 9:5 and data bits 2:0 go to temporary bits 14:12. Every such write flips the toggle.
- R4: Writes to index 6 also depend on the toggle. With the toggle at 0, data bits 5:0 go to temporary bits 13:8 and bit 14 is cleared. With the toggle at 1, data goes to temporary bits 7:0 and the whole temporary pointer is copied into the current pointer. Every such write flips the toggle.
- R5: A write to index 7 issues `vram_wr` with the write data at current pointer bits 13:0. Any access to index 7 then advances the current pointer by 1, or by 32 when control bit 2 is set. The pointer wraps at 15 bits.
- R6: A read of index 7 issues `vram_rd` and loads the fetched byte into the read buffer. Below 0x3F00 the read returns the previous buffer contents. From 0x3F00 upward (pointer bits 13:8 all ones) it returns the fetched byte directly.
- R7: The blanking flag sets on the cycle where scanline 241 and dot 1 are presented. A raster set wins over a status read in the same cycle.
- R8: A read of index 2 returns blanking, hit and overflow in bits 7, 6 and 5, and bus-latch bits 4:0 in bits 4:0. The read clears the blanking flag and the write toggle.
- R9: The hit strobe sets status bit 6 and the overflow strobe sets status bit 5. Scanline 261 with dot 1 clears both of them and the blanking flag.
- R10: The irq output is high exactly while control bit 7 and the blanking flag are both set.
- R11: A write to index 3 sets the sprite pointer. A write to index 4 stores the byte at the pointer and then increments the pointer, wrapping from 255 to 0. A read of index 4 returns the byte at the pointer and leaves the pointer unchanged.
- R12: Every access updates the bus latch with the written byte or the returned byte. Reads of indices 0, 1, 3, 5 and 6 return the latch unchanged. A write to index 2 has no effect beyond updating the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | Register access strobe, one cycle per access |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register index |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid in the access cycle |
| line | input | 9 | Current scanline from the timing counter |
| dot | input | 9 | Current dot from the timing counter |
| hit_strobe | input | 1 | Sprite-zero hit event |
| ovf_strobe | input | 1 | Sprite overflow event |
| irq | output | 1 | Vertical-blank interrupt request |
| ctrl_bits | output | 8 | Control register contents |
| mask_bits | output | 8 | Mask register contents |
| tmp_addr | output | 15 | Temporary pointer |
| cur_addr | output | 15 | Current pointer |
| fine_x | output | 3 | Fine horizontal scroll |
| vram_addr | output | 14 | VRAM access address |
| vram_rd | output | 1 | VRAM read request |
| vram_wr | output | 1 | VRAM write request |
| vram_wdata | output | 8 | VRAM write data |
| vram_rdata | input | 8 | VRAM read data, same cycle as request |

## Verification
A wrong write toggle shows on the pointer outputs on the cycle after the next scroll or pointer write, because the byte lands in the wrong bit field. A stale read buffer shows only on the second data-port read, so the bench always compares consecutive reads. Flag errors stay hidden until a status read or an irq edge exposes them. For that reason, raster events are interleaved with status reads, and irq is compared after every step.

// File: rtl/vid_regif_pkg.sv
// Shared register index names and the pointer field layout.
package vid_regif_pkg;

    typedef enum logic [2:0] {
        RIX_CTRL = 3'd0,
        RIX_MASK = 3'd1,
        RIX_STAT = 3'd2,
        RIX_SPTR = 3'd3,
        RIX_SDAT = 3'd4,
        RIX_SCRL = 3'd5,
        RIX_VPTR = 3'd6,
        RIX_VDAT = 3'd7
    } reg_ix_e;

    // Pointer layout, MSB first: fine Y, nametable, coarse Y, coarse X.
    typedef struct packed {
        logic [2:0] fy;
        logic [1:0] nt;
        logic [4:0] cy;
        logic [4:0] cx;
    } vptr_t;

    localparam int PTR_W    = 15;
    localparam int VRAM_AW  = 14;
    localparam int STEP_ROW = 32;

endpackage

// File: rtl/vid_regif_scroll.sv
// Scroll and VRAM pointer state: temporary/current pointers, fine X and
// the shared first/second write toggle.
// Assumes at most one of the write/read pulses is high per cycle.
module vid_regif_scroll
    import vid_regif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctrl,
    input  logic             wr_scrl,
    input  logic             wr_vptr,
    input  logic             rd_stat,
    input  logic             dat_acc,
    input  logic             step_row,
    input  logic [7:0]       wdata,
    output logic [PTR_W-1:0] tmp_o,
    output logic [PTR_W-1:0] cur_o,
    output logic [2:0]       fx_o,
    output logic             tog_o
);

    vptr_t            tmp_q;
    logic [PTR_W-1:0] cur_q;
    logic [2:0]       fx_q;
    logic             tog_q;
    logic [PTR_W-1:0] step;

    // Pointer advance amount selected by control bit 2.
    always_comb step = step_row ? PTR_W'(STEP_ROW) : PTR_W'(1);

    // Temporary pointer, fine X and toggle updates from the register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmp_q <= '0;
            fx_q  <= '0;
            tog_q <= 1'b0;
        end else if (wr_ctrl) begin
            tmp_q.nt <= wdata[1:0];
        end else if (wr_scrl) begin
            if (!tog_q) begin
                tmp_q.cx <= wdata[7:3];
                fx_q     <= wdata[2:0];
            end else begin
                tmp_q.cy <= wdata[7:3];
                tmp_q.fy <= wdata[2:0];
            end
            tog_q <= ~tog_q;
        end else if (wr_vptr) begin
            if (!tog_q) begin
                tmp_q[14]   <= 1'b0;
                tmp_q[13:8] <= wdata[5:0];
            end else begin
                tmp_q[7:0] <= wdata;
            end
            tog_q <= ~tog_q;
        end else if (rd_stat) begin
            tog_q <= 1'b0;
        end
    end

    // Current pointer: loaded on the second pointer write, stepped on data access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_q <= '0;
        else if (wr_vptr && tog_q)
            cur_q <= {tmp_q[14:8], wdata};
        else if (dat_acc)
            cur_q <= cur_q + step;
    end

    assign tmp_o = tmp_q;
    assign cur_o = cur_q;
    assign fx_o  = fx_q;
    assign tog_o = tog_q;

endmodule

// File: rtl/vid_regif_flags.sv
// Status flags: blanking, sprite-zero hit and sprite overflow.
// Assumes line/dot come from a free-running raster counter; a raster set
// of the blanking flag wins over a status read in the same cycle.
module vid_regif_flags #(
    parameter int LINE_W   = 9,
    parameter int VBL_LINE = 241,
    parameter int PRE_LINE = 261,
    parameter int FLAG_DOT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line,
    input  logic [LINE_W-1:0] dot,
    input  logic              hit_in,
    input  logic              ovf_in,
    input  logic              rd_stat,
    output logic              vbl_o,
    output logic              hit_o,
    output logic              ovf_o
);

    localparam logic [LINE_W-1:0] VBL_L = LINE_W'(VBL_LINE);
    localparam logic [LINE_W-1:0] PRE_L = LINE_W'(PRE_LINE);
    localparam logic [LINE_W-1:0] FLG_D = LINE_W'(FLAG_DOT);

    logic at_vbl, at_pre;
    logic vbl_q, hit_q, ovf_q;

    // Raster position decode.
    always_comb begin
        at_vbl = (line == VBL_L) && (dot == FLG_D);
        at_pre = (line == PRE_L) && (dot == FLG_D);
    end

    // Flag set/clear sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbl_q <= 1'b0;
            hit_q <= 1'b0;
            ovf_q <= 1'b0;
        end else if (at_pre) begin
            vbl_q <= 1'b0;
            hit_q <= 1'b0;
            ovf_q <= 1'b0;
        end else begin
            if (at_vbl)       vbl_q <= 1'b1;
            else if (rd_stat) vbl_q <= 1'b0;
            if (hit_in)       hit_q <= 1'b1;
            if (ovf_in)       ovf_q <= 1'b1;
        end
    end

    assign vbl_o = vbl_q;
    assign hit_o = hit_q;
    assign ovf_o = ovf_q;

endmodule

// File: rtl/vid_regif_oam.sv
// Sprite attribute store with its auto-incrementing byte pointer.
// Assumes a pointer write and a data write never share a cycle.
module vid_regif_oam #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ptr_wr,
    input  logic          dat_wr,
    input  logic [AW-1:0] wdata,
    output logic [7:0]    rdata,
    output logic [AW-1:0] ptr_o
);

    localparam int DEPTH = 1 << AW;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] ptr_q;

    // Byte pointer: loaded by its register, stepped after each data write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (ptr_wr)
            ptr_q <= wdata;
        else if (dat_wr)
            ptr_q <= ptr_q + AW'(1);
    end

    // Storage array, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (dat_wr) begin
            mem[ptr_q] <= wdata[7:0];
        end
    end

    assign rdata = mem[ptr_q];
    assign ptr_o = ptr_q;

endmodule

// File: rtl/vid_regif.sv
// CPU register interface of the video engine: decodes the eight register
// indices, holds control/mask, the bus latch and the VRAM read buffer,
// and routes accesses to the scroll, flag and sprite-store submodules.
// Assumes VRAM returns vram_rdata combinationally in the vram_rd cycle.
module vid_regif
    import vid_regif_pkg::*;
#(
    parameter int LINE_W   = 9,
    parameter int VBL_LINE = 241,
    parameter int PRE_LINE = 261,
    parameter int FLAG_DOT = 1,
    parameter int OAM_AW   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_sel,
    input  logic                cpu_wr,
    input  logic [2:0]          cpu_addr,
    input  logic [7:0]          cpu_wdata,
    output logic [7:0]          cpu_rdata,
    input  logic [LINE_W-1:0]   line,
    input  logic [LINE_W-1:0]   dot,
    input  logic                hit_strobe,
    input  logic                ovf_strobe,
    output logic                irq,
    output logic [7:0]          ctrl_bits,
    output logic [7:0]          mask_bits,
    output logic [PTR_W-1:0]    tmp_addr,
    output logic [PTR_W-1:0]    cur_addr,
    output logic [2:0]          fine_x,
    output logic [VRAM_AW-1:0]  vram_addr,
    output logic                vram_rd,
    output logic                vram_wr,
    output logic [7:0]          vram_wdata,
    input  logic [7:0]          vram_rdata
);

    localparam logic [5:0] PAL_PAGE = 6'h3F;

    reg_ix_e          ix;
    logic             wr_ctrl, wr_mask, wr_sptr, wr_sdat, wr_scrl, wr_vptr;
    logic             rd_stat, dat_acc, rd_vdat;
    logic [7:0]       ctrl_q, mask_q, bus_q, rbuf_q;
    logic             scr_w;
    logic             vbl_f, hit_f, ovf_f;
    logic [7:0]       oam_rd;
    logic [OAM_AW-1:0] oam_ptr;
    logic             pal_zone;

    // Register index decode into one-cycle access pulses.
    always_comb begin
        ix      = reg_ix_e'(cpu_addr);
        wr_ctrl = cpu_sel &&  cpu_wr && (ix == RIX_CTRL);
        wr_mask = cpu_sel &&  cpu_wr && (ix == RIX_MASK);
        wr_sptr = cpu_sel &&  cpu_wr && (ix == RIX_SPTR);
        wr_sdat = cpu_sel &&  cpu_wr && (ix == RIX_SDAT);
        wr_scrl = cpu_sel &&  cpu_wr && (ix == RIX_SCRL);
        wr_vptr = cpu_sel &&  cpu_wr && (ix == RIX_VPTR);
        rd_stat = cpu_sel && !cpu_wr && (ix == RIX_STAT);
        dat_acc = cpu_sel && (ix == RIX_VDAT);
        rd_vdat = dat_acc && !cpu_wr;
    end

    vid_regif_scroll u_scroll (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wr_scrl  (wr_scrl),
        .wr_vptr  (wr_vptr),
        .rd_stat  (rd_stat),
        .dat_acc  (dat_acc),
        .step_row (ctrl_q[2]),
        .wdata    (cpu_wdata),
        .tmp_o    (tmp_addr),
        .cur_o    (cur_addr),
        .fx_o     (fine_x),
        .tog_o    (scr_w)
    );

    vid_regif_flags #(
        .LINE_W   (LINE_W),
        .VBL_LINE (VBL_LINE),
        .PRE_LINE (PRE_LINE),
        .FLAG_DOT (FLAG_DOT)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .line    (line),
        .dot     (dot),
        .hit_in  (hit_strobe),
        .ovf_in  (ovf_strobe),
        .rd_stat (rd_stat),
        .vbl_o   (vbl_f),
        .hit_o   (hit_f),
        .ovf_o   (ovf_f)
    );

    vid_regif_oam #(
        .AW (OAM_AW)
    ) u_oam (
        .clk    (clk),
        .rst_n  (rst_n),
        .ptr_wr (wr_sptr),
        .dat_wr (wr_sdat),
        .wdata  (cpu_wdata[OAM_AW-1:0]),
        .rdata  (oam_rd),
        .ptr_o  (oam_ptr)
    );

    // Palette region detect on the current pointer.
    always_comb pal_zone = (cur_addr[13:8] == PAL_PAGE);

    // Read data mux for the access cycle.
    always_comb begin
        case (ix)
            RIX_STAT: cpu_rdata = {vbl_f, hit_f, ovf_f, bus_q[4:0]};
            RIX_SDAT: cpu_rdata = oam_rd;
            RIX_VDAT: cpu_rdata = pal_zone ? vram_rdata : rbuf_q;
            default:  cpu_rdata = bus_q;
        endcase
    end

    // Control and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= cpu_wdata;
            if (wr_mask) mask_q <= cpu_wdata;
        end
    end

    // Bus latch tracks the last byte moved in either direction.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_q <= '0;
        else if (cpu_sel)
            bus_q <= cpu_wr ? cpu_wdata : cpu_rdata;
    end

    // One-byte VRAM read buffer, refilled on every data-port read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rbuf_q <= '0;
        else if (rd_vdat)
            rbuf_q <= vram_rdata;
    end

    assign irq        = ctrl_q[7] & vbl_f;
    assign ctrl_bits  = ctrl_q;
    assign mask_bits  = mask_q;
    assign vram_addr  = cur_addr[VRAM_AW-1:0];
    assign vram_rd    = rd_vdat;
    assign vram_wr    = dat_acc && cpu_wr;
    assign vram_wdata = cpu_wdata;

endmodule

// File: rtl/vid_regif_chk.sv
// Temporal checks on the register interface, bound into every vid_regif.
module vid_regif_chk #(
    parameter int LINE_W   = 9,
    parameter int VBL_LINE = 241,
    parameter int PRE_LINE = 261,
    parameter int FLAG_DOT = 1,
    parameter int OAM_AW   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_sel,
    input logic              cpu_wr,
    input logic [2:0]        cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic [LINE_W-1:0] line,
    input logic [LINE_W-1:0] dot,
    input logic              hit_strobe,
    input logic              irq,
    input logic [7:0]        ctrl_q,
    input logic [14:0]       tmp_addr,
    input logic [14:0]       cur_addr,
    input logic              scr_w,
    input logic [OAM_AW-1:0] oam_ptr,
    input logic              vbl_f,
    input logic              hit_f,
    input logic              ovf_f
);

    localparam logic [LINE_W-1:0] VBL_L = LINE_W'(VBL_LINE);
    localparam logic [LINE_W-1:0] PRE_L = LINE_W'(PRE_LINE);
    localparam logic [LINE_W-1:0] FLG_D = LINE_W'(FLAG_DOT);

    assert_vbl_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line == VBL_L && dot == FLG_D && ctrl_q[7] &&
         !(cpu_sel && cpu_wr && cpu_addr == 3'd0)) |=> irq)
        else $error("blanking start did not raise irq");

    assert_pre_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (line == PRE_L && dot == FLG_D) |=> (!vbl_f && !hit_f && !ovf_f && !irq))
        else $error("pre-render dot did not clear flags");

    assert_hit_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_strobe && !(line == PRE_L && dot == FLG_D)) |=> hit_f)
        else $error("hit strobe lost");

    assert_stat_tog_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && !cpu_wr && cpu_addr == 3'd2) |=> !scr_w)
        else $error("status read left toggle set");

    assert_ptr_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr && cpu_addr == 3'd6 && scr_w) |=>
        (cur_addr == {$past(tmp_addr[14:8]), $past(cpu_wdata)}))
        else $error("second pointer write did not load current pointer");

    assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_addr == 3'd7) |=>
        (cur_addr == $past(cur_addr) + ($past(ctrl_q[2]) ? 15'd32 : 15'd1)))
        else $error("data access step wrong");

    assert_oam_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && cpu_wr && cpu_addr == 3'd4) |=> (oam_ptr == $past(oam_ptr) + OAM_AW'(1)))
        else $error("sprite pointer did not advance");

endmodule

bind vid_regif vid_regif_chk #(
    .LINE_W   (LINE_W),
    .VBL_LINE (VBL_LINE),
    .PRE_LINE (PRE_LINE),
    .FLAG_DOT (FLAG_DOT),
    .OAM_AW   (OAM_AW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_sel    (cpu_sel),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .line       (line),
    .dot        (dot),
    .hit_strobe (hit_strobe),
    .irq        (irq),
    .ctrl_q     (ctrl_q),
    .tmp_addr   (tmp_addr),
    .cur_addr   (cur_addr),
    .scr_w      (scr_w),
    .oam_ptr    (oam_ptr),
    .vbl_f      (vbl_f),
    .hit_f      (hit_f),
    .ovf_f      (ovf_f)
);

// File: tb/vid_regif_bench.sv
// Self-checking bench: directed corners, then seeded random accesses,
// compared against a bench-side model of the requirements.
module vid_regif_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_sel, cpu_wr;
    logic [2:0]  cpu_addr;
    logic [7:0]  cpu_wdata, cpu_rdata;
    logic [8:0]  line, dot;
    logic        hit_strobe, ovf_strobe, irq;
    logic [7:0]  ctrl_bits, mask_bits;
    logic [14:0] tmp_addr, cur_addr;
    logic [2:0]  fine_x;
    logic [13:0] vram_addr;
    logic        vram_rd, vram_wr;
    logic [7:0]  vram_wdata, vram_rdata;

    int total = 0;
    int bad   = 0;

    // Model state.
    logic [14:0] m_t, m_v;
    logic [2:0]  m_x;
    logic        m_w, m_vbl, m_hit, m_ovf;
    logic [7:0]  m_ctrl, m_mask, m_bus, m_buf, m_op;
    logic [7:0]  m_oam [256];
    logic [7:0]  vmem  [2048];

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_regif u_vid_regif (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .line(line), .dot(dot), .hit_strobe(hit_strobe), .ovf_strobe(ovf_strobe),
        .irq(irq), .ctrl_bits(ctrl_bits), .mask_bits(mask_bits),
        .tmp_addr(tmp_addr), .cur_addr(cur_addr), .fine_x(fine_x),
        .vram_addr(vram_addr), .vram_rd(vram_rd), .vram_wr(vram_wr),
        .vram_wdata(vram_wdata), .vram_rdata(vram_rdata)
    );

    // Small VRAM model, low 11 address bits, combinational read.
    assign vram_rdata = vmem[vram_addr[10:0]];
    always @(posedge clk) if (vram_wr) vmem[vram_addr[10:0]] <= vram_wdata;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic string lab_of(input logic [2:0] a, input bit wr);
        case (a)
            3'd0: return wr ? "R2" : "R12";
            3'd2: return wr ? "R12" : "R8";
            3'd3, 3'd4: return "R11";
            3'd5: return wr ? "R3" : "R12";
            3'd6: return wr ? "R4" : "R12";
            3'd7: return wr ? "R5" : "R6";
            default: return "R12";
        endcase
    endfunction

    task automatic chk_state(input string lab);
        chk(tmp_addr == m_t, {lab, " tmp"}, tmp_addr, m_t);
        chk(cur_addr == m_v, {lab, " cur"}, cur_addr, m_v);
        chk(fine_x == m_x, {lab, " fx"}, fine_x, m_x);
        chk(ctrl_bits == m_ctrl, {lab, " ctrl"}, ctrl_bits, m_ctrl);
        chk(mask_bits == m_mask, {lab, " mask"}, mask_bits, m_mask);
        chk(irq == (m_ctrl[7] & m_vbl), "R10 irq", irq, m_ctrl[7] & m_vbl);
    endtask

    task automatic do_acc(input bit wr, input logic [2:0] a, input logic [7:0] d, output logic [7:0] got);
        logic [7:0] exp;
        string lab;
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        #1;
        got = cpu_rdata;
        exp = m_bus;
        lab = lab_of(a, wr);
        case (a)
            3'd0: if (wr) begin m_ctrl = d; m_t[11:10] = d[1:0]; end
            3'd1: if (wr) m_mask = d;
            3'd2: if (!wr) begin exp = {m_vbl, m_hit, m_ovf, m_bus[4:0]}; m_vbl = 1'b0; m_w = 1'b0; end
            3'd3: if (wr) m_op = d;
            3'd4: if (wr) begin m_oam[m_op] = d; m_op = m_op + 8'd1; end
                  else exp = m_oam[m_op];
            3'd5: if (wr) begin
                      if (!m_w) begin m_t[4:0] = d[7:3]; m_x = d[2:0]; end
                      else begin m_t[9:5] = d[7:3]; m_t[14:12] = d[2:0]; end
                      m_w = !m_w;
                  end
            3'd6: if (wr) begin
                      if (!m_w) begin m_t[13:8] = d[5:0]; m_t[14] = 1'b0; end
                      else begin m_t[7:0] = d; m_v = m_t; end
                      m_w = !m_w;
                  end
            default: begin
                if (!wr) begin
                    exp = (m_v[13:8] == 6'h3F) ? vmem[m_v[10:0]] : m_buf;
                    m_buf = vmem[m_v[10:0]];
                end else begin
                    chk(vram_wr && vram_addr == m_v[13:0], "R5 vram_wr", {vram_wr, vram_addr}, {1'b1, m_v[13:0]});
                end
                m_v = m_v + (m_ctrl[2] ? 15'd32 : 15'd1);
            end
        endcase
        if (!wr) chk(got == exp, {lab, " rdata"}, got, exp);
        m_bus = wr ? d : exp;
        @(posedge clk);
        @(negedge clk);
        cpu_sel = 1'b0; cpu_wr = 1'b0;
        chk_state(lab);
    endtask

    task automatic rast(input int l, input int d, input bit hs, input bit os);
        @(negedge clk);
        line = 9'(l); dot = 9'(d); hit_strobe = hs; ovf_strobe = os;
        if (l == 261 && d == 1) begin
            m_vbl = 1'b0; m_hit = 1'b0; m_ovf = 1'b0;
        end else begin
            if (l == 241 && d == 1) m_vbl = 1'b1;
            if (hs) m_hit = 1'b1;
            if (os) m_ovf = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        line = '0; dot = '0; hit_strobe = 1'b0; ovf_strobe = 1'b0;
        chk(irq == (m_ctrl[7] & m_vbl), "R10 raster irq", irq, m_ctrl[7] & m_vbl);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog R1 act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0]  g;
        logic [31:0] r;
        r = $urandom(32'd4711);
        for (int i = 0; i < 2048; i++) vmem[i] = 8'(i * 7 + 3);
        for (int i = 0; i < 256; i++) m_oam[i] = '0;
        m_t = '0; m_v = '0; m_x = '0; m_w = 0; m_vbl = 0; m_hit = 0; m_ovf = 0;
        m_ctrl = '0; m_mask = '0; m_bus = '0; m_buf = '0; m_op = '0;
        rst_n = 1'b0; cpu_sel = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
        line = '0; dot = '0; hit_strobe = 0; ovf_strobe = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(tmp_addr == 0 && cur_addr == 0 && fine_x == 0, "R1 pointers", {tmp_addr, cur_addr}, 0);
        chk(irq == 0 && ctrl_bits == 0 && mask_bits == 0, "R1 regs", {irq, ctrl_bits, mask_bits}, 0);
        do_acc(0, 3'd2, 8'h00, g);
        chk(g == 8'h00, "R1 status", g, 0);

        // R2 nametable bits
        do_acc(1, 3'd0, 8'h03, g);
        chk(tmp_addr[11:10] == 2'b11, "R2 nt", tmp_addr[11:10], 3);

        // R3 scroll pair
        do_acc(1, 3'd5, 8'h7D, g);
        chk(fine_x == 3'd5 && tmp_addr[4:0] == 5'h0F, "R3 first", {fine_x, tmp_addr[4:0]}, {3'd5, 5'h0F});
        do_acc(1, 3'd5, 8'h5E, g);
        chk(tmp_addr[9:5] == 5'h0B && tmp_addr[14:12] == 3'd6, "R3 second", tmp_addr, {3'd6, 12'h0});

        // R4 pointer pair into palette page; R6 direct palette read
        vmem[11'h710] = 8'hA5;
        vmem[11'h100] = 8'h5A;
        do_acc(1, 3'd6, 8'h7F, g);
        chk(tmp_addr[14] == 1'b0 && tmp_addr[13:8] == 6'h3F, "R4 high", tmp_addr[14:8], 7'h3F);
        do_acc(1, 3'd6, 8'h10, g);
        chk(cur_addr == 15'h3F10, "R4 copy", cur_addr, 15'h3F10);
        do_acc(0, 3'd7, 8'h00, g);
        chk(g == 8'hA5, "R6 palette direct", g, 8'hA5);
        do_acc(1, 3'd6, 8'h01, g);
        do_acc(1, 3'd6, 8'h00, g);
        do_acc(0, 3'd7, 8'h00, g);
        chk(g == 8'hA5, "R6 stale buffer", g, 8'hA5);
        do_acc(0, 3'd7, 8'h00, g);
        chk(g == 8'h5A, "R6 buffered", g, 8'h5A);

        // R5 row step
        do_acc(1, 3'd0, 8'h04, g);
        do_acc(1, 3'd7, 8'h99, g);
        chk(cur_addr == 15'h0122, "R5 step32", cur_addr, 15'h0122);

        // R7 / R10 / R8 blanking cycle
        do_acc(1, 3'd0, 8'h80, g);
        rast(241, 1, 0, 0);
        chk(irq == 1'b1, "R7 irq high", irq, 1);
        do_acc(0, 3'd2, 8'h00, g);
        chk(g[7] == 1'b1, "R7 status bit7", g, 8'h80);
        chk(irq == 1'b0, "R8 read clears", irq, 0);

        // R9 event flags and pre-render clear
        rast(10, 5, 1, 1);
        do_acc(0, 3'd2, 8'h00, g);
        chk(g[6:5] == 2'b11, "R9 flags set", g[6:5], 3);
        rast(241, 1, 0, 0);
        rast(261, 1, 0, 0);
        do_acc(0, 3'd2, 8'h00, g);
        chk(g[7:5] == 3'b000, "R9 pre clear", g[7:5], 0);

        // R11 sprite pointer wrap and read
        do_acc(1, 3'd3, 8'hFF, g);
        do_acc(1, 3'd4, 8'h11, g);
        do_acc(1, 3'd3, 8'hFF, g);
        do_acc(0, 3'd4, 8'h00, g);
        chk(g == 8'h11, "R11 wrap store", g, 8'h11);

        // R12 write-only reads return latch; status write ignored
        do_acc(1, 3'd1, 8'h96, g);
        do_acc(0, 3'd0, 8'h00, g);
        chk(g == 8'h96, "R12 latch", g, 8'h96);
        do_acc(1, 3'd2, 8'hE0, g);
        do_acc(0, 3'd2, 8'h00, g);
        chk(g == 8'h00, "R12 status write ignored", g, 8'h00);

        // Random phase
        for (int i = 0; i < 1500; i++) begin
            r = $urandom;
            if (r[3:0] == 4'd0)
                rast(r[17:16] == 2'd0 ? 241 : (r[17:16] == 2'd1 ? 261 : 0),
                     int'(r[18]), r[19], r[20]);
            else
                do_acc(r[4], r[7:5], r[15:8], g);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule